// File: doc/BRIEF.md
# Bipolar DAC code corrector

This block turns a signed request for a bipolar offset DAC into the unsigned code that is actually written to the converter. First it adds a signed offset calibration term to the request. It then scales the sum by an unsigned gain term, where 0x8000 stands for a factor of one. Last, it moves the result into offset-binary form, in which 0x8000 is zero volts, 0xFFFF is the positive reference and 0x0000 is the negative reference.

Requests enter through a valid/ready handshake. Each result leaves, with its own valid flag, a fixed three pipeline stages later. When the downstream side stops taking results, the pipeline holds its contents without losing or repeating any of them. A result that falls outside the code range is pinned to the nearer rail, and a saturation flag travels with it.

Top module: `dac_code_corrector`

## Requirements
- R1: For value v and offset o (16-bit two's complement) and gain g (16-bit unsigned), the code is floor((v+o)*g / 32768) + 32768 whenever that value lies in 0..65535. In that case out_sat is 0.
- R2: When v+o equals zero, the code is 0x8000 for every gain.
- R3: With gain 0x8000, the code is (v+o)+32768. A two's complement input therefore comes out in offset-binary form.
- R4: The sum v+o is formed at 17 bits and never wraps. For example, v=0x7FFF, o=0x7FFF, g=0x2000 gives 49151 with out_sat 0.
- R5: The division by 32768 rounds toward negative infinity. For example, v=-1, o=0, g=1 gives 32767, and v=0, o=-1, g=0x4000 also gives 32767.
- R6: A result above 65535 yields code 0xFFFF with out_sat 1. A result below 0 yields code 0x0000 with out_sat 1.
- R7: A request accepted at a clock edge while the pipeline is empty and out_ready is high shows out_valid on the third clock edge, counting the accepting edge as the first.
- R8: While out_valid is high and out_ready is low, out_code and out_sat hold steady. Every accepted request produces exactly one result, in order. With out_ready held high, one request is accepted every cycle.
- R9: While reset (active-low rst_n) is asserted, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request will be taken at the next edge |
| in_value | input | 16 | Requested value, two's complement |
| in_offset | input | 16 | Offset calibration, two's complement |
| in_gain | input | 16 | Gain calibration, unsigned, 0x8000 is unity |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result at the next edge |
| out_code | output | 16 | Offset-binary DAC code |
| out_sat | output | 1 | Result was clamped to a rail |

## Verification
The assertions assume that the downstream side follows the handshake: it samples out_code only on a cycle when both out_valid and out_ready are high. They also assume that in_value, in_offset and in_gain are steady whenever in_valid is high. The bench changes its inputs only just after a clock edge, and only after the request it was holding has been taken. Its backpressure comes from a pseudo-random out_ready pattern, which produces the stall cycles that the hold checks watch.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_LOW  = 2'd1,
    SAT_HIGH = 2'd2
  } dcc_sat_e;
endpackage

// File: rtl/dcc_slice.sv
module dcc_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  // a slice accepts when empty or when its content leaves this cycle
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (up_ready && up_valid) dn_data <= up_data;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
endmodule

// File: rtl/dcc_sum_stage.sv
module dcc_sum_stage #(
  parameter int VAL_W = 16,
  localparam int SUM_W = VAL_W + 1
) (
  input  logic [VAL_W-1:0] value,
  input  logic [VAL_W-1:0] offset,
  output logic [SUM_W-1:0] sum
);
  function automatic logic [SUM_W-1:0] wide_add(logic [VAL_W-1:0] a, logic [VAL_W-1:0] b);
    logic [SUM_W-1:0] ea, eb;
    ea = {a[VAL_W-1], a};
    eb = {b[VAL_W-1], b};
    return ea + eb;
  endfunction

  assign sum = wide_add(value, offset);
endmodule

// File: rtl/dcc_scale_stage.sv
module dcc_scale_stage #(
  parameter int SUM_W     = 17,
  parameter int GAIN_W    = 16,
  parameter int FRAC_BITS = 15,
  localparam int PROD_W = SUM_W + GAIN_W + 1,
  localparam int SCL_W  = PROD_W - FRAC_BITS
) (
  input  logic [SUM_W-1:0]  sum,
  input  logic [GAIN_W-1:0] gain,
  output logic [SCL_W-1:0]  scaled
);
  // arithmetic shift of the signed product: floor division by 2^FRAC_BITS
  function automatic logic [SCL_W-1:0] mul_shift(logic [SUM_W-1:0] s, logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] a, b, p, q;
    a = {{(PROD_W-SUM_W){s[SUM_W-1]}}, s};
    b = {{(PROD_W-GAIN_W){1'b0}}, g};
    p = a * b;
    q = p >>> FRAC_BITS;
    return q[SCL_W-1:0];
  endfunction

  assign scaled = mul_shift(sum, gain);
endmodule

// File: rtl/dcc_bias_stage.sv
module dcc_bias_stage #(
  parameter int SCL_W  = 19,
  parameter int CODE_W = 16,
  localparam int BIAS_W = SCL_W + 1
) (
  input  logic [SCL_W-1:0]  scaled,
  output logic [CODE_W-1:0] code,
  output dcc_pkg::dcc_sat_e kind
);
  localparam logic signed [BIAS_W-1:0] MID  = BIAS_W'(1) << (CODE_W - 1);
  localparam logic signed [BIAS_W-1:0] TOPV = (BIAS_W'(1) << CODE_W) - BIAS_W'(1);

  function automatic logic signed [BIAS_W-1:0] add_mid(logic [SCL_W-1:0] x);
    logic signed [BIAS_W-1:0] ex;
    ex = {x[SCL_W-1], x};
    return ex + MID;
  endfunction

  function automatic dcc_pkg::dcc_sat_e rail_of(logic signed [BIAS_W-1:0] b);
    if (b < 0)         return dcc_pkg::SAT_LOW;
    else if (b > TOPV) return dcc_pkg::SAT_HIGH;
    else               return dcc_pkg::SAT_NONE;
  endfunction

  function automatic logic [CODE_W-1:0] clamp(logic signed [BIAS_W-1:0] b, dcc_pkg::dcc_sat_e k);
    case (k)
      dcc_pkg::SAT_LOW:  return '0;
      dcc_pkg::SAT_HIGH: return '1;
      default:           return b[CODE_W-1:0];
    endcase
  endfunction

  logic signed [BIAS_W-1:0] biased;
  assign biased = add_mid(scaled);
  assign kind   = rail_of(biased);
  assign code   = clamp(biased, kind);
endmodule

// File: rtl/dac_code_corrector.sv
module dac_code_corrector #(
  parameter int VAL_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int FRAC_BITS = 15,
  parameter int CODE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VAL_W-1:0]  in_value,
  input  logic [VAL_W-1:0]  in_offset,
  input  logic [GAIN_W-1:0] in_gain,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic              out_sat
);
  localparam int SUM_W  = VAL_W + 1;
  localparam int PROD_W = SUM_W + GAIN_W + 1;
  localparam int SCL_W  = PROD_W - FRAC_BITS;
  localparam int S1_W   = SUM_W + GAIN_W;
  localparam int S3_W   = CODE_W + 1;

  // stage 1: wide sum, gain carried along
  logic [SUM_W-1:0]  sum_c;
  logic [S1_W-1:0]   s1_data;
  logic              s1_valid, s1_ready;

  dcc_sum_stage #(.VAL_W(VAL_W)) u_sum (
    .value(in_value), .offset(in_offset), .sum(sum_c));

  dcc_slice #(.W(S1_W)) u_s1 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data({sum_c, in_gain}),
    .dn_valid(s1_valid), .dn_ready(s1_ready), .dn_data(s1_data));

  // stage 2: gain scaling
  logic [SCL_W-1:0] scl_c, s2_data;
  logic             s2_valid, s2_ready;

  dcc_scale_stage #(.SUM_W(SUM_W), .GAIN_W(GAIN_W), .FRAC_BITS(FRAC_BITS)) u_scale (
    .sum(s1_data[S1_W-1:GAIN_W]), .gain(s1_data[GAIN_W-1:0]), .scaled(scl_c));

  dcc_slice #(.W(SCL_W)) u_s2 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s1_valid), .up_ready(s1_ready), .up_data(scl_c),
    .dn_valid(s2_valid), .dn_ready(s2_ready), .dn_data(s2_data));

  // stage 3: mid-scale bias and rail clamp
  logic [CODE_W-1:0]  code_c;
  dcc_pkg::dcc_sat_e  kind_c;
  logic [S3_W-1:0]    s3_data;

  dcc_bias_stage #(.SCL_W(SCL_W), .CODE_W(CODE_W)) u_bias (
    .scaled(s2_data), .code(code_c), .kind(kind_c));

  dcc_slice #(.W(S3_W)) u_s3 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s2_valid), .up_ready(s2_ready),
    .up_data({kind_c != dcc_pkg::SAT_NONE, code_c}),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(s3_data));

  assign out_sat  = s3_data[CODE_W];
  assign out_code = s3_data[CODE_W-1:0];

  p_rail_on_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |-> (out_code == '0) || (out_code == '1));

  p_ready_when_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stage_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_ready |=> s2_valid);

  p_no_hold_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s2_valid));
endmodule

// File: tb/dac_code_corrector_tb.sv
module dac_code_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_value = '0, in_offset = '0, in_gain = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_code;
  logic        out_sat;

  always #2.5 clk = ~clk;

  dac_code_corrector u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_offset(in_offset), .in_gain(in_gain),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_sat(out_sat));

  int errors = 0, checks = 0;
  int exp_q[$];
  bit sat_q[$];
  string tag_q[$];
  int cur_exp; bit cur_sat; string cur_tag;
  bit accepted, seen_ov, bp_on = 0, hold_pend = 0, held_sat;
  logic [15:0] held_code;
  logic [7:0] lfsr = 8'hA5;
  int sent = 0, got = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // restated arithmetic: integer floor division, explicit bias and clamp
  function automatic int model(int v, int o, int g, output bit sat);
    longint s, p, q;
    s = longint'(v) + longint'(o);
    p = s * longint'(g);
    q = p / 32768;
    if (p < 0 && (p % 32768) != 0) q = q - 1;
    q = q + 32768;
    sat = 0;
    if (q < 0) begin q = 0; sat = 1; end
    else if (q > 65535) begin q = 65535; sat = 1; end
    return int'(q);
  endfunction

  task automatic cycle();
    @(negedge clk);
    seen_ov = out_valid;
    if (hold_pend) begin
      chk(out_valid == 1'b1, "R8 hold valid", int'(out_valid), 1);
      chk(out_code == held_code && out_sat == held_sat, "R8 hold data",
          int'(out_code), int'(held_code));
    end
    hold_pend = out_valid && !out_ready;
    held_code = out_code; held_sat = out_sat;
    if (out_valid && out_ready) begin
      got++;
      if (exp_q.size() == 0) chk(0, "R8 extra result", int'(out_code), -1);
      else begin
        int e; bit es; string t;
        e = exp_q.pop_front(); es = sat_q.pop_front(); t = tag_q.pop_front();
        chk(int'(out_code) == e, t, int'(out_code), e);
        chk(out_sat == es, {t, " sat"}, int'(out_sat), int'(es));
      end
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      sent++;
      exp_q.push_back(cur_exp); sat_q.push_back(cur_sat); tag_q.push_back(cur_tag);
    end
    @(posedge clk); #1;
    if (bp_on) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[3];
    end else out_ready = 1'b1;
  endtask

  task automatic send(int v, int o, int g);
    bit s;
    in_value = 16'(v); in_offset = 16'(o); in_gain = 16'(g);
    cur_exp = model(v, o, g, s); cur_sat = s;
    if (s) cur_tag = "R6";
    else if (v + o == 0) cur_tag = "R2";
    else if (g == 32768) cur_tag = "R3";
    else cur_tag = "R1";
    in_valid = 1'b1;
    do cycle(); while (!accepted);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    for (int k = 0; k < 400 && exp_q.size() > 0; k++) cycle();
    repeat (3) cycle();
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 10; c++) begin
          int g;
          g = (c < 8) ? c * 9362 : ((c == 8) ? 32768 : 65535);
          send(-32768 + a * 4369, -32768 + b * 9362, g);
        end
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b1;

    // R7 latency on an empty pipeline
    begin
      int n;
      send(10, 5, 32768);
      in_valid = 1'b0;
      n = 0;
      do begin n++; cycle(); end while (!seen_ov && n < 10);
      chk(n == 3, "R7 latency", n, 3);
      drain();
    end

    // R8 full throughput: four back-to-back requests take four cycles
    begin
      int t0;
      t0 = sent;
      for (int k = 0; k < 4; k++) send(k * 1000, -k, 40000);
      chk(sent - t0 == 4, "R8 throughput", sent - t0, 4);
      drain();
    end

    // corner cases
    send(32767, 32767, 16'h2000); cur_tag = "R4";
    tag_q[tag_q.size()-1] = "R4 wide sum";
    send(-1, 0, 1);               tag_q[tag_q.size()-1] = "R5 floor a";
    send(0, -1, 16'h4000);        tag_q[tag_q.size()-1] = "R5 floor b";
    send(32767, 32767, 16'hFFFF); tag_q[tag_q.size()-1] = "R6 high rail";
    send(-32768, -32768, 16'hFFFF); tag_q[tag_q.size()-1] = "R6 low rail";
    send(100, -100, 16'hFFFF);    tag_q[tag_q.size()-1] = "R2 zero sum";
    send(-32768, 0, 32768);       tag_q[tag_q.size()-1] = "R3 unity neg";
    drain();

    sweep();
    bp_on = 1;
    sweep();
    bp_on = 0;
    drain();
    chk(got == sent, "R8 count in==out", got, sent);
    chk(exp_q.size() == 0, "R8 nothing missing", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule